// File: doc/BRIEF.md
# Age-Ordered Wave Schedule Queue

This block sits between the stage that picks candidate wave instructions from a ready pool and the execution resource that consumes them. Each accepted candidate becomes one slot that holds its wave identifier, a 16-bit sequence stamp taken at insert time, and a two-state operand status. Slots stay sorted from the oldest stamp to the youngest, so the oldest wave always gets the first chance to move forward.

A new candidate enters in the busy state. It turns ready once the operand-read-complete line for its wave has been seen high. The exit port shows the oldest ready slot whenever the target resource is ready. Taking it closes the gap, and the slots behind it move up one place. A wave that lost arbitration further down the pipe comes back through the reinsert port with its original stamp. It lands at the place its age calls for, and it is already ready.

Inserts are refused in three cases: the wave is already queued, the register files cannot serve the access, or no slot is free. The last two cases each have their own saturating counter. A third counter records the cycles in which operand reads hold back a busy slot.

Top module: `wave_sched_queue`

## Requirements
- R1: Slots are kept sorted by age, oldest first. The exit port shows the lowest-positioned slot whose status is ready, so of the ready waves the oldest leaves first.
- R2: A newly inserted slot starts busy (status 0). It becomes ready (status 1) in the cycle after a clock edge at which `opd_done[wave]` was high. A busy slot is never offered at the exit.
- R3: An insert whose wave ID matches a slot present at the start of the cycle, or a reinsert in the same cycle, is refused. No counter moves and the occupancy does not change.
- R4: An insert with `ins_rf_ok` low, for a wave that is not a duplicate, is refused and increments `rf_stall_cnt` by one. This applies even when the queue is full, and in that case `full_stall_cnt` stays unchanged.
- R5: `pop_valid` is high only while `res_ready` is high and some slot is ready. When `pop_valid` and `pop_take` are both high at a clock edge, that slot is removed and the slots behind it move up with their order kept.
- R6: A reinsert places its wave, with the stamp it supplies and status ready, ahead of the first slot with a younger stamp. It does not go to the tail.
- R7: The queue holds at most DEPTH slots. An insert that is not a duplicate, has `ins_rf_ok` high and finds no free slot after this cycle's removal and reinsert is refused, and it increments `full_stall_cnt` by one.
- R8: `opd_stall_cnt` increments at each clock edge at which at least one busy slot has its `opd_done` line low.
- R9: Stamps come from a 16-bit sequence that starts at 0 and advances by one on each accepted new insert. Age is compared through wrapping subtraction, so stamp 0xFFFF counts as older than a later stamp 0x0000.
- R10: After a synchronous reset the queue is empty, `pop_valid` is low, all counters read 0 and the sequence restarts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | New candidate present |
| ins_wave | input | WID_W | Wave ID of the new candidate |
| ins_rf_ok | input | 1 | Register files can serve this candidate |
| opd_done | input | 2**WID_W | Operand reads complete, one line per wave ID |
| res_ready | input | 1 | Target execution resource can accept |
| pop_take | input | 1 | Consumer takes the offered slot |
| rin_valid | input | 1 | Reinsert of a wave that lost arbitration |
| rin_wave | input | WID_W | Wave ID being reinserted |
| rin_age | input | AGE_W | Original stamp of the reinserted wave |
| pop_valid | output | 1 | A slot is offered |
| pop_wave | output | WID_W | Wave ID of the offered slot |
| pop_age | output | AGE_W | Stamp of the offered slot |
| q_count | output | clog2(DEPTH+1) | Current occupancy |
| rf_stall_cnt | output | CNT_W | Refusals caused by register-file limits |
| full_stall_cnt | output | CNT_W | Refusals caused by a full queue |
| opd_stall_cnt | output | CNT_W | Cycles with a busy slot held back by operands |

## Verification
A slot stored out of place, or shifted wrongly on removal, shows up at the exit port on the next take: the offered wave ID or stamp breaks the arithmetic sequence the bench expects. A stuck or early status bit shows up one cycle after the operand line changes, as `pop_valid` or `pop_wave` being wrong. A bad wrap comparison shows only when stamps straddle 0xFFFF/0x0000, so the bench drives the sequence across that point and then checks where the reinsert lands. Counter faults appear in the counter value right after the edge of the offending insert.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
  typedef enum logic {
    OPD_BUSY  = 1'b0,
    OPD_READY = 1'b1
  } opd_state_e;
endpackage

// File: rtl/wsq_age_older.sv
// Wrap-safe age comparison: a is older than b when (a - b) is negative.
module wsq_age_older #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         older
);
  logic [W-1:0] diff;
  assign diff  = a - b;
  assign older = diff[W-1];
endmodule

// File: rtl/wsq_pick.sv
// Lowest-index set bit finder.
module wsq_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wsq_ctr.sv
// Saturating event counter.
module wsq_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (inc && ~&cnt)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wave_sched_queue.sv
module wave_sched_queue
  import wsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WID_W = 4,
  parameter int AGE_W = 16,
  parameter int CNT_W = 16,
  localparam int NWAVE = 1 << WID_W,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_valid,
  input  logic [WID_W-1:0] ins_wave,
  input  logic             ins_rf_ok,
  input  logic [NWAVE-1:0] opd_done,
  input  logic             res_ready,
  input  logic             pop_take,
  input  logic             rin_valid,
  input  logic [WID_W-1:0] rin_wave,
  input  logic [AGE_W-1:0] rin_age,
  output logic             pop_valid,
  output logic [WID_W-1:0] pop_wave,
  output logic [AGE_W-1:0] pop_age,
  output logic [OCC_W-1:0] q_count,
  output logic [CNT_W-1:0] rf_stall_cnt,
  output logic [CNT_W-1:0] full_stall_cnt,
  output logic [CNT_W-1:0] opd_stall_cnt
);
  localparam logic [OCC_W-1:0] FULL_CNT = OCC_W'(DEPTH);

  // Stored slots
  logic [DEPTH-1:0]                  vld_q;
  logic [DEPTH-1:0][WID_W-1:0]       wave_q;
  logic [DEPTH-1:0][AGE_W-1:0]       age_q;
  opd_state_e [DEPTH-1:0]            st_q;
  logic [AGE_W-1:0]                  seq_q;
  logic [OCC_W-1:0]                  cnt_q;

  // Exit selection
  logic [DEPTH-1:0] rdy_vec;
  logic             any_rdy;
  logic [IDX_W-1:0] pop_idx;
  logic             pop_fire;

  always_comb
    for (int i = 0; i < DEPTH; i++)
      rdy_vec[i] = vld_q[i] && (st_q[i] == OPD_READY);

  wsq_pick #(.N(DEPTH), .IW(IDX_W)) u_pop_pick (
    .req(rdy_vec), .found(any_rdy), .idx(pop_idx)
  );

  assign pop_valid = any_rdy && res_ready;
  assign pop_wave  = wave_q[pop_idx];
  assign pop_age   = age_q[pop_idx];
  assign pop_fire  = pop_valid && pop_take;
  assign q_count   = cnt_q;

  // Stage A: status refresh and removal of the taken slot (compaction)
  logic [DEPTH-1:0]            a_vld;
  logic [DEPTH-1:0][WID_W-1:0] a_wave;
  logic [DEPTH-1:0][AGE_W-1:0] a_age;
  opd_state_e [DEPTH-1:0]      a_st;
  logic [OCC_W-1:0]            a_cnt;

  always_comb begin
    int k;
    k      = 0;
    a_vld  = '0;
    a_wave = '0;
    a_age  = '0;
    for (int i = 0; i < DEPTH; i++) a_st[i] = OPD_BUSY;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && !(pop_fire && pop_idx == IDX_W'(i))) begin
        a_vld[k]  = 1'b1;
        a_wave[k] = wave_q[i];
        a_age[k]  = age_q[i];
        a_st[k]   = (st_q[i] == OPD_READY || opd_done[wave_q[i]]) ? OPD_READY : OPD_BUSY;
        k++;
      end
    end
    a_cnt = OCC_W'(k);
  end

  // Reinsert position: ahead of the first slot younger than rin_age
  logic [DEPTH-1:0] rin_before;
  logic [DEPTH-1:0] place_mask;
  logic             pos_found;
  logic [IDX_W-1:0] pos_idx;
  logic [OCC_W-1:0] rin_pos;
  logic             rin_acc;

  for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
    wsq_age_older #(.W(AGE_W)) u_cmp (
      .a(rin_age), .b(a_age[j]), .older(rin_before[j])
    );
    assign place_mask[j] = a_vld[j] && rin_before[j];
  end

  wsq_pick #(.N(DEPTH), .IW(IDX_W)) u_pos_pick (
    .req(place_mask), .found(pos_found), .idx(pos_idx)
  );

  assign rin_pos = pos_found ? OCC_W'(pos_idx) : a_cnt;
  assign rin_acc = rin_valid && (a_cnt < FULL_CNT);

  // Insert qualification
  logic dup_hit, ins_ok, rf_refuse, full_refuse, opd_blk;
  logic [OCC_W-1:0] b_cnt;

  always_comb begin
    dup_hit = rin_valid && (rin_wave == ins_wave);
    opd_blk = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && wave_q[i] == ins_wave) dup_hit = 1'b1;
      if (vld_q[i] && st_q[i] == OPD_BUSY && !opd_done[wave_q[i]]) opd_blk = 1'b1;
    end
  end

  assign b_cnt       = a_cnt + OCC_W'(rin_acc);
  assign rf_refuse   = ins_valid && !dup_hit && !ins_rf_ok;
  assign full_refuse = ins_valid && !dup_hit && ins_rf_ok && (b_cnt >= FULL_CNT);
  assign ins_ok      = ins_valid && !dup_hit && ins_rf_ok && (b_cnt < FULL_CNT);

  // Stage B: reinsert shift, then new insert at the tail
  logic [DEPTH-1:0]            n_vld;
  logic [DEPTH-1:0][WID_W-1:0] n_wave;
  logic [DEPTH-1:0][AGE_W-1:0] n_age;
  opd_state_e [DEPTH-1:0]      n_st;

  always_comb begin
    n_vld  = a_vld;
    n_wave = a_wave;
    n_age  = a_age;
    n_st   = a_st;
    if (rin_acc) begin
      for (int j = 1; j < DEPTH; j++) begin
        if (OCC_W'(j) > rin_pos) begin
          n_vld[j]  = a_vld[j-1];
          n_wave[j] = a_wave[j-1];
          n_age[j]  = a_age[j-1];
          n_st[j]   = a_st[j-1];
        end
      end
      for (int j = 0; j < DEPTH; j++) begin
        if (OCC_W'(j) == rin_pos) begin
          n_vld[j]  = 1'b1;
          n_wave[j] = rin_wave;
          n_age[j]  = rin_age;
          n_st[j]   = OPD_READY;
        end
      end
    end
    if (ins_ok) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (OCC_W'(j) == b_cnt) begin
          n_vld[j]  = 1'b1;
          n_wave[j] = ins_wave;
          n_age[j]  = seq_q;
          n_st[j]   = OPD_BUSY;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      cnt_q <= '0;
      seq_q <= '0;
    end else begin
      vld_q <= n_vld;
      cnt_q <= b_cnt + OCC_W'(ins_ok);
      if (ins_ok) seq_q <= seq_q + 1'b1;
    end
  end

  // Payload registers carry no reset; validity is tracked by vld_q.
  always_ff @(posedge clk) begin
    wave_q <= n_wave;
    age_q  <= n_age;
    st_q   <= n_st;
  end

  // Stall counters
  logic [2:0]            ctr_inc;
  logic [2:0][CNT_W-1:0] ctr_val;
  assign ctr_inc = {opd_blk, full_refuse, rf_refuse};

  for (genvar g = 0; g < 3; g++) begin : g_ctr
    wsq_ctr #(.W(CNT_W)) u_ctr (
      .clk(clk), .rst(rst), .inc(ctr_inc[g]), .cnt(ctr_val[g])
    );
  end

  assign rf_stall_cnt   = ctr_val[0];
  assign full_stall_cnt = ctr_val[1];
  assign opd_stall_cnt  = ctr_val[2];
endmodule

// File: rtl/wsq_chk.sv
module wsq_chk #(
  parameter int DEPTH = 8,
  parameter int WID_W = 4,
  parameter int AGE_W = 16,
  parameter int CNT_W = 16,
  parameter int OCC_W = 4
) (
  input logic                        clk,
  input logic                        rst,
  input logic [DEPTH-1:0]            vld_q,
  input logic [DEPTH-1:0][WID_W-1:0] wave_q,
  input logic [DEPTH-1:0][AGE_W-1:0] age_q,
  input logic [OCC_W-1:0]            q_count,
  input logic                        pop_valid,
  input logic                        res_ready,
  input logic                        ins_valid,
  input logic                        ins_rf_ok,
  input logic [CNT_W-1:0]            rf_stall_cnt,
  input logic [CNT_W-1:0]            full_stall_cnt
);
  for (genvar j = 0; j + 1 < DEPTH; j++) begin : g_ord
    logic [AGE_W-1:0] d;
    assign d = age_q[j] - age_q[j+1];
    // R1, R9: stored slots packed at the front and ordered oldest first
    p_sorted_r1: assert property (@(posedge clk) disable iff (rst)
      vld_q[j+1] |-> (vld_q[j] && d[AGE_W-1]));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_u_i
    for (genvar j = i + 1; j < DEPTH; j++) begin : g_u_j
      p_unique_r3: assert property (@(posedge clk) disable iff (rst)
        (vld_q[i] && vld_q[j]) |-> (wave_q[i] != wave_q[j]));
    end
  end

  p_capacity_r7: assert property (@(posedge clk) disable iff (rst)
    q_count <= OCC_W'(DEPTH));

  p_occ_match_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(vld_q) == int'(q_count));

  p_pop_gate_r5: assert property (@(posedge clk) disable iff (rst)
    pop_valid |-> res_ready);

  p_rf_cnt_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(rf_stall_cnt) |-> $past(ins_valid && !ins_rf_ok));

  p_full_cnt_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(full_stall_cnt) |-> $past(ins_valid && ins_rf_ok));
endmodule

bind wave_sched_queue wsq_chk #(
  .DEPTH(DEPTH), .WID_W(WID_W), .AGE_W(AGE_W), .CNT_W(CNT_W), .OCC_W(OCC_W)
) u_chk (
  .clk(clk), .rst(rst), .vld_q(vld_q), .wave_q(wave_q), .age_q(age_q),
  .q_count(q_count), .pop_valid(pop_valid), .res_ready(res_ready),
  .ins_valid(ins_valid), .ins_rf_ok(ins_rf_ok),
  .rf_stall_cnt(rf_stall_cnt), .full_stall_cnt(full_stall_cnt)
);

// File: tb/sim_wave_sched_queue.sv
`timescale 1ns/1ps
module sim_wave_sched_queue;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0, ins_rf_ok = 1'b0, res_ready = 1'b0, pop_take = 1'b0;
  logic [3:0]  ins_wave = '0, rin_wave = '0;
  logic [15:0] opd_done = '0;
  logic        rin_valid = 1'b0;
  logic [15:0] rin_age = '0;
  logic        pop_valid;
  logic [3:0]  pop_wave;
  logic [15:0] pop_age;
  logic [3:0]  q_count;
  logic [15:0] rf_cnt, full_cnt, opd_cnt;

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_seq = '0;

  always #10 clk = ~clk;

  wave_sched_queue u0 (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_wave(ins_wave),
    .ins_rf_ok(ins_rf_ok), .opd_done(opd_done), .res_ready(res_ready),
    .pop_take(pop_take), .rin_valid(rin_valid), .rin_wave(rin_wave),
    .rin_age(rin_age), .pop_valid(pop_valid), .pop_wave(pop_wave),
    .pop_age(pop_age), .q_count(q_count), .rf_stall_cnt(rf_cnt),
    .full_stall_cnt(full_cnt), .opd_stall_cnt(opd_cnt)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] w, input logic ok);
    ins_valid = 1'b1; ins_wave = w; ins_rf_ok = ok;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10 count", q_count, 0);
    chk("R10 pop_valid", pop_valid, 0);
    chk("R10 counters", rf_cnt + full_cnt + opd_cnt, 0);

    res_ready = 1'b1;
    put(4'd1, 1'b1); exp_seq++;
    @(negedge clk); put(4'd2, 1'b1); exp_seq++;
    @(negedge clk); put(4'd3, 1'b1); exp_seq++;
    @(negedge clk); ins_valid = 1'b0;
    chk("R2 count after three inserts", q_count, 3);
    chk("R2 busy slots not offered", pop_valid, 0);
    chk("R8 operand stall cycles", opd_cnt, 2);
    opd_done[3] = 1'b1;

    @(negedge clk);
    chk("R2 only ready wave offered", pop_wave, 3);
    chk("R9 stamp of third insert", pop_age, 2);
    chk("R8 stall keeps counting", opd_cnt, 3);
    opd_done = '1; res_ready = 1'b0;

    @(negedge clk);
    chk("R8 no stall once operands done", opd_cnt, 3);
    chk("R5 resource not ready", pop_valid, 0);
    res_ready = 1'b1; #1;
    chk("R1 oldest ready wave", pop_wave, 1);
    chk("R1 oldest stamp", pop_age, 0);
    put(4'd2, 1'b1);                       // duplicate

    @(negedge clk);
    chk("R3 duplicate occupancy", q_count, 3);
    chk("R3 duplicate counters", rf_cnt + full_cnt, 0);
    put(4'd4, 1'b0);                       // register files cannot serve

    @(negedge clk); ins_valid = 1'b0;
    chk("R4 refused occupancy", q_count, 3);
    chk("R4 rf counter", rf_cnt, 1);
    pop_take = 1'b1;

    @(negedge clk); pop_take = 1'b0;
    chk("R5 occupancy after take", q_count, 2);
    chk("R5 next wave moves up", pop_wave, 2);
    rin_valid = 1'b1; rin_wave = 4'd1; rin_age = 16'd0;

    @(negedge clk); rin_valid = 1'b0;
    chk("R6 occupancy after reinsert", q_count, 3);
    chk("R6 reinsert at age place", pop_wave, 1);
    chk("R6 reinsert stamp", pop_age, 0);

    for (int w = 4; w <= 8; w++) begin
      put(w[3:0], 1'b1); exp_seq++;
      @(negedge clk);
    end
    chk("R7 full occupancy", q_count, 8);
    put(4'd9, 1'b1);
    @(negedge clk);
    chk("R7 full counter", full_cnt, 1);
    chk("R7 occupancy capped", q_count, 8);
    put(4'd10, 1'b0);
    @(negedge clk); ins_valid = 1'b0;
    chk("R4 rf refusal wins when full", rf_cnt, 2);
    chk("R4 full counter unchanged", full_cnt, 1);

    pop_take = 1'b1;
    for (int k = 0; k < 8; k++) begin
      chk("R1 drain order wave", pop_wave, k + 1);
      chk("R1 drain order stamp", pop_age, k);
      @(negedge clk);
    end
    chk("R5 drained", q_count, 0);
    chk("R9 sequence count", exp_seq, 8);

    // Run the sequence up to 0xFFFF through a flowing stream
    for (int i = 0; exp_seq != 16'hFFFF; i++) begin
      put(4'(i % 8), 1'b1); exp_seq++;
      @(negedge clk);
    end
    ins_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 stream drained", q_count, 0);

    opd_done = '0; pop_take = 1'b0; res_ready = 1'b0;
    put(4'd5, 1'b1); exp_seq++;
    @(negedge clk); put(4'd6, 1'b1); exp_seq++;
    @(negedge clk); ins_valid = 1'b0; opd_done[5] = 1'b1; opd_done[6] = 1'b1;
    @(negedge clk); opd_done = '0; res_ready = 1'b1; #1;
    chk("R9 wave before wrap offered", pop_wave, 5);
    chk("R9 stamp before wrap", pop_age, 16'hFFFF);
    pop_take = 1'b1;
    @(negedge clk); pop_take = 1'b0;
    chk("R9 stamp after wrap", pop_age, 0);
    rin_valid = 1'b1; rin_wave = 4'd5; rin_age = 16'hFFFF;
    @(negedge clk); rin_valid = 1'b0;
    chk("R6 R9 wrapped reinsert ahead", pop_wave, 5);
    chk("R6 occupancy", q_count, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule